// File: doc/BRIEF.md
# Load-Use Stall and Decode Branch Flush Control

This block governs the front of a five-stage in-order pipeline. It owns the program counter and the fetch/decode pipeline register, and decides each cycle whether fetch moves ahead, holds, or is redirected. When the instruction in execute is a load whose destination register is a source of the instruction in decode, it freezes the PC and the fetch/decode register for one cycle. It also tells the decode control path to send down all-zero controls, so a single bubble enters execute.

Branches are resolved in decode. The decoder raises a branch flag. The block compares the two register values read for that instruction, and on equality it redirects fetch to the branch target. The target is the incremented PC held with the decode instruction plus the sign-extended offset times four. The instruction fetched behind the branch is replaced by an all-zero word, so a taken branch costs one slot. Fetch otherwise runs sequentially, which means branches are predicted not taken. A stall takes precedence over a branch in the same cycle. The branch is then evaluated again once the bubble has been inserted.

Top module: `hazard_ctrl`

## Requirements
- R1: After reset the PC is 0, the fetch/decode register holds the all-zero word and is marked invalid, and `ctrl_zero` is 1.
- R2: A stall occurs when the decode entry is valid, `ex_mem_read` is 1, and `ex_rt` equals the decode instruction's source field rs (bits 25:21) or its field rt (bits 20:16). In no other case does a stall occur.
- R3: While a stall is active, `ctrl_zero` is 1.
- R4: While a stall is active, `pc_we` and `ifid_we` are 0. At the next edge, `pc`, `ifid_instr` and `ifid_pc_inc` keep their values.
- R5: A branch is taken when the decode entry is valid, `id_branch` is 1, `id_rs_val` equals `id_rt_val`, and no stall is active. `br_target` is always `ifid_pc_inc + (id_imm << 2)`.
- R6: For a taken branch, `ifid_flush` and `pc_sel` are 1 in that cycle. At the next edge, `pc` becomes `br_target` and `ifid_instr` becomes 0 and invalid, so `ctrl_zero` is 1.
- R7: With no stall and no taken branch, the next edge sets `pc` to `pc+4`, loads `fetch_instr` into `ifid_instr`, and sets `ifid_pc_inc` to the old `pc+4`.
- R8: When a stall and a taken-branch condition occur together, the stall wins and no flush is raised. Once the load condition clears, the same branch is taken.
- R9: An invalid decode entry never causes a stall or a taken branch, and it keeps `ctrl_zero` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_instr | input | 32 | Instruction word read at `pc` |
| ex_mem_read | input | 1 | Execute-stage instruction is a load |
| ex_rt | input | 5 | Destination register of the execute-stage load |
| id_branch | input | 1 | Decode instruction is a branch-on-equal |
| id_rs_val | input | 32 | First register value read in decode |
| id_rt_val | input | 32 | Second register value read in decode |
| id_imm | input | 32 | Sign-extended branch offset (in words) |
| pc | output | 32 | Program counter |
| ifid_instr | output | 32 | Instruction held in the fetch/decode register |
| ifid_pc_inc | output | 32 | Incremented PC of the decode instruction |
| pc_we | output | 1 | PC advances this cycle |
| ifid_we | output | 1 | Fetch/decode register loads this cycle |
| ctrl_zero | output | 1 | Force decode controls to zero (bubble) |
| ifid_flush | output | 1 | Fetch/decode register is cleared at the next edge |
| pc_sel | output | 1 | Next PC comes from the branch target |
| br_target | output | 32 | Branch target address |

## Verification
A stale validity bit shows up as a stall or flush on the all-zero word, or as a missing bubble. This is visible on `pc_we` and `ctrl_zero` in the first cycle after reset or after a flush. A wrong field slice or priority shows up in the same cycle as the offending inputs, as a wrong `pc_we` or `ifid_flush`. A wrong target or hold shows up in `pc` one edge later. The bench therefore checks the combinational controls as soon as it drives the inputs, and checks the registered state right after the following edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int WORD_W = 32;
    localparam int STEP   = 4;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] instr;
        logic [WORD_W-1:0] pc_inc;
        logic              valid;
    } fe_state_t;
endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int REG_AW = 5,
    parameter int RS_LSB = 21,
    parameter int RT_LSB = 16,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [WORD_W-1:0] dec_instr,
    input  logic              ex_mem_read,
    input  logic [REG_AW-1:0] ex_rt,
    output logic              stall
);
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;

    always_comb begin
        src_a = dec_instr[RS_LSB +: REG_AW];
        src_b = dec_instr[RT_LSB +: REG_AW];
        stall = dec_valid && ex_mem_read && ((ex_rt == src_a) || (ex_rt == src_b));
    end

    // R9
    invalid_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);
endmodule

// File: rtl/hz_branch_unit.sv
module hz_branch_unit #(
    parameter int WORD_W = 32
) (
    input  logic              dec_valid,
    input  logic              is_branch,
    input  logic              stall,
    input  logic [WORD_W-1:0] val_a,
    input  logic [WORD_W-1:0] val_b,
    input  logic [WORD_W-1:0] pc_inc,
    input  logic [WORD_W-1:0] imm,
    output logic              taken,
    output logic [WORD_W-1:0] target
);
    logic [WORD_W-1:0] offset;

    always_comb begin
        offset = {imm[WORD_W-3:0], 2'b00};
        target = pc_inc + offset;
        taken  = dec_valid && is_branch && (val_a == val_b) && !stall;
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hz_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int RS_LSB = 21,
    parameter int RT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fetch_instr,
    input  logic              ex_mem_read,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic              id_branch,
    input  logic [WORD_W-1:0] id_rs_val,
    input  logic [WORD_W-1:0] id_rt_val,
    input  logic [WORD_W-1:0] id_imm,
    output logic [WORD_W-1:0] pc,
    output logic [WORD_W-1:0] ifid_instr,
    output logic [WORD_W-1:0] ifid_pc_inc,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              ctrl_zero,
    output logic              ifid_flush,
    output logic              pc_sel,
    output logic [WORD_W-1:0] br_target
);
    localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP);

    fe_state_t st_d, st_q;
    logic stall;
    logic taken;
    logic [WORD_W-1:0] tgt;

    hz_load_use #(
        .REG_AW(REG_AW), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB), .WORD_W(WORD_W)
    ) u_load_use (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (st_q.valid),
        .dec_instr  (st_q.instr),
        .ex_mem_read(ex_mem_read),
        .ex_rt      (ex_rt),
        .stall      (stall)
    );

    hz_branch_unit #(.WORD_W(WORD_W)) u_branch (
        .dec_valid(st_q.valid),
        .is_branch(id_branch),
        .stall    (stall),
        .val_a    (id_rs_val),
        .val_b    (id_rt_val),
        .pc_inc   (st_q.pc_inc),
        .imm      (id_imm),
        .taken    (taken),
        .target   (tgt)
    );

    always_comb begin
        st_d = st_q;
        if (stall) begin
            st_d = st_q;
        end else if (taken) begin
            st_d.pc     = tgt;
            st_d.instr  = '0;
            st_d.pc_inc = '0;
            st_d.valid  = 1'b0;
        end else begin
            st_d.pc     = st_q.pc + STEP_W;
            st_d.instr  = fetch_instr;
            st_d.pc_inc = st_q.pc + STEP_W;
            st_d.valid  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pc          = st_q.pc;
        ifid_instr  = st_q.instr;
        ifid_pc_inc = st_q.pc_inc;
        pc_we       = !stall;
        ifid_we     = !stall;
        ctrl_zero   = stall || !st_q.valid;
        ifid_flush  = taken;
        pc_sel      = taken;
        br_target   = tgt;
    end

    // R4
    stall_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> (pc == $past(pc)) && (ifid_instr == $past(ifid_instr)));

    // R6
    flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |=> (ifid_instr == '0) && ctrl_zero && (pc == $past(br_target)));

    // R8
    stall_over_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifid_flush && !pc_we));

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !pc_sel) |=> (pc == $past(pc) + STEP_W) && (ifid_pc_inc == pc));

    // R3
    stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we |-> ctrl_zero);
endmodule

// File: tb/hazard_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_instr = '0;
    logic        ex_mem_read = 1'b0;
    logic [4:0]  ex_rt = '0;
    logic        id_branch = 1'b0;
    logic [31:0] id_rs_val = '0;
    logic [31:0] id_rt_val = '0;
    logic [31:0] id_imm = '0;
    logic [31:0] pc, ifid_instr, ifid_pc_inc, br_target;
    logic        pc_we, ifid_we, ctrl_zero, ifid_flush, pc_sel;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hazard_ctrl u_hazard_ctrl (
        .clk(clk), .rst_n(rst_n), .fetch_instr(fetch_instr),
        .ex_mem_read(ex_mem_read), .ex_rt(ex_rt), .id_branch(id_branch),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val), .id_imm(id_imm),
        .pc(pc), .ifid_instr(ifid_instr), .ifid_pc_inc(ifid_pc_inc),
        .pc_we(pc_we), .ifid_we(ifid_we), .ctrl_zero(ctrl_zero),
        .ifid_flush(ifid_flush), .pc_sel(pc_sel), .br_target(br_target)
    );

    function automatic logic [31:0] mk(input logic [4:0] rs, input logic [4:0] rt);
        return {6'b100011, rs, rt, 16'h00AB};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        ex_mem_read = 0; ex_rt = 0; id_branch = 0;
        id_rs_val = 0; id_rt_val = 1; id_imm = 0;
    endtask

    task automatic load_ifid(input logic [31:0] w);
        quiet();
        fetch_instr = w;
        #1;
        tick();
    endtask

    task automatic t_reset();
        rst_n = 0;
        quiet();
        tick(); tick();
        chk(pc == 0, "R1 pc", pc, 0);
        chk(ifid_instr == 0, "R1 ifid", ifid_instr, 0);
        chk(ctrl_zero == 1, "R1 ctrl_zero", 32'(ctrl_zero), 1);
        // R9: invalid entry ignores a matching load and an equal branch
        ex_mem_read = 1; ex_rt = 0; id_branch = 1; id_rs_val = 5; id_rt_val = 5;
        #1;
        chk(pc_we == 1, "R9 no stall", 32'(pc_we), 1);
        chk(ifid_flush == 0, "R9 no flush", 32'(ifid_flush), 0);
        rst_n = 1;
        quiet();
    endtask

    task automatic t_seq();
        logic [31:0] p;
        p = pc;
        load_ifid(mk(5'd1, 5'd2));
        chk(pc == p + 4, "R7 pc step", pc, p + 4);
        chk(ifid_instr == mk(5'd1, 5'd2), "R7 ifid word", ifid_instr, mk(5'd1, 5'd2));
        chk(ifid_pc_inc == p + 4, "R7 pc_inc", ifid_pc_inc, p + 4);
        chk(ctrl_zero == 0, "R9 valid entry no bubble", 32'(ctrl_zero), 0);
    endtask

    task automatic t_stall(input bit use_rt);
        logic [31:0] p, w;
        w = use_rt ? mk(5'd3, 5'd9) : mk(5'd9, 5'd3);
        load_ifid(w);
        p = pc;
        ex_mem_read = 1; ex_rt = 5'd9; fetch_instr = 32'hDEADBEEF;
        #1;
        chk(pc_we == 0 && ifid_we == 0, "R2 stall raised", {30'd0, pc_we, ifid_we}, 0);
        chk(ctrl_zero == 1, "R3 bubble", 32'(ctrl_zero), 1);
        tick();
        chk(pc == p, "R4 pc held", pc, p);
        chk(ifid_instr == w, "R4 ifid held", ifid_instr, w);
        quiet();
    endtask

    task automatic t_no_stall();
        load_ifid(mk(5'd4, 5'd6));
        ex_mem_read = 1; ex_rt = 5'd7;
        #1;
        chk(pc_we == 1, "R2 no match", 32'(pc_we), 1);
        ex_mem_read = 0; ex_rt = 5'd4;
        #1;
        chk(pc_we == 1 && ctrl_zero == 0, "R2 no load", {30'd0, pc_we, ctrl_zero}, 32'h2);
        quiet();
    endtask

    task automatic t_branch(input logic [31:0] imm);
        logic [31:0] inc, tgt;
        load_ifid(mk(5'd2, 5'd3));
        inc = ifid_pc_inc;
        tgt = inc + (imm << 2);
        id_branch = 1; id_rs_val = 32'h55; id_rt_val = 32'h55; id_imm = imm;
        #1;
        chk(ifid_flush && pc_sel, "R6 flush", {30'd0, ifid_flush, pc_sel}, 3);
        chk(br_target == tgt, "R5 target", br_target, tgt);
        tick();
        chk(pc == tgt, "R6 pc redirect", pc, tgt);
        chk(ifid_instr == 0 && ctrl_zero, "R6 zero word", ifid_instr, 0);
        quiet();
    endtask

    task automatic t_not_taken();
        logic [31:0] p;
        load_ifid(mk(5'd2, 5'd3));
        p = pc;
        id_branch = 1; id_rs_val = 1; id_rt_val = 2; id_imm = 32'h10;
        #1;
        chk(pc_sel == 0, "R5 unequal not taken", 32'(pc_sel), 0);
        tick();
        chk(pc == p + 4, "R7 sequential after not taken", pc, p + 4);
        quiet();
    endtask

    task automatic t_priority();
        logic [31:0] p, tgt;
        load_ifid(mk(5'd7, 5'd8));
        p = pc;
        tgt = ifid_pc_inc + 32'h20;
        ex_mem_read = 1; ex_rt = 5'd7;
        id_branch = 1; id_rs_val = 9; id_rt_val = 9; id_imm = 32'h8;
        #1;
        chk(ifid_flush == 0 && pc_we == 0, "R8 stall wins", {30'd0, ifid_flush, pc_we}, 0);
        tick();
        chk(pc == p, "R8 pc held", pc, p);
        ex_mem_read = 0;
        #1;
        chk(ifid_flush == 1, "R8 branch retaken", 32'(ifid_flush), 1);
        tick();
        chk(pc == tgt, "R8 redirect after bubble", pc, tgt);
        quiet();
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_seq();
        t_stall(1'b0);
        t_stall(1'b1);
        t_no_stall();
        t_branch(32'h0000_0003);
        t_branch(32'hFFFF_FFFD);
        t_not_taken();
        t_priority();
        t_seq();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule